// File: doc/BRIEF.md
# Return stack with interrupt sequencer

This block keeps the return addresses of a small DSP core and decides when one of its interrupt requests is taken. The core presents a call strobe with its current program counter, a return strobe, a pulse marking the end of each instruction and a strobe for the instruction that turns interrupts on. Calls push the address two words past the call, and returns expose the top entry for the core to load into its program counter, then drop it. The stack is a six-entry, 16-bit last-in first-out store with sticky overflow and underflow flags.

Three request lines are watched for rising edges. Each edge leaves a pending flag that stays set until that level is acknowledged. At an instruction boundary where interrupts are enabled, the highest pending level (line 0 first) is taken. The block then runs a fixed two-cycle entry. It stalls the core, pulses a one-hot acknowledge with the level index, pushes the program counter sampled at the boundary and clears the global enable. Only the enable strobe sets the enable again.

Top module: `retstk_irq_seq`

## Requirements
- R1: When call_i is high and stall_o is low, pc_i+2 is pushed. ret_pc_o always shows the top entry. When ret_i is high, the top entry is removed, so addresses come back in last-in first-out order.
- R2: The stack holds six entries. A push onto a full stack sets overflow_o, which stays set until reset, and leaves every entry and ret_pc_o unchanged.
- R3: A pop from an empty stack sets underflow_o, which stays set until reset. An empty stack shows 0 on ret_pc_o.
- R4: A 0-to-1 change of irq_i[k] sets pending_o[k] on the next clock. A line held high does not set the flag again.
- R5: An interrupt is accepted only in a cycle where insn_end_i is high, gie_o is high, pending_o is not zero and stall_o is low.
- R6: Level 0 has the highest priority and level 2 the lowest. In the cycle after acceptance, ack_o is one-hot for the chosen level and vec_o holds its index (0, 1 or 2). The chosen pending bit clears and the other pending bits are kept.
- R7: stall_o is high for exactly the two cycles after acceptance. The pc_i value sampled at the accepting boundary is pushed unchanged, and a later return shows it.
- R8: Acceptance clears gie_o, and only ei_i sets it. When ei_i is high in the same cycle as an acceptance, the acceptance wins and gie_o goes to 0.
- R9: call_i and ret_i are ignored while stall_o is high. When both are high in the same cycle, the call is performed and the return is ignored.
- R10: Reset empties the stack and clears pending_o, gie_o, overflow_o, underflow_o, ack_o and stall_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call strobe |
| pc_i | input | 16 | Current program counter |
| ret_i | input | 1 | Return strobe |
| insn_end_i | input | 1 | Instruction boundary pulse |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| irq_i | input | 3 | Interrupt request lines |
| ret_pc_o | output | 16 | Top-of-stack address |
| ack_o | output | 3 | One-hot acknowledge |
| vec_o | output | 2 | Acknowledged level index |
| stall_o | output | 1 | Entry sequence in progress |
| gie_o | output | 1 | Global interrupt enable |
| pending_o | output | 3 | Pending request flags |
| overflow_o | output | 1 | Sticky push-on-full flag |
| underflow_o | output | 1 | Sticky pop-on-empty flag |

## Verification
The hardest case to reach from the ports is an interrupt taken while the stack is already full or nearly full, together with several pending levels and an enable strobe that coincides with the acceptance. The stimulus first fills the stack with calls. It then raises two request lines before the enable is set, so both are pending when the boundary pulse comes. A further request line is still held high across its own acknowledge, which checks that a level is not retaken. A seeded random phase of calls, returns and overlapping strobes is compared against a bench model of the stack.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int PC_W = 16;
  localparam int NREQ = 3;
  localparam int VEC_W = $clog2(NREQ);

  typedef enum logic [1:0] {
    ENT_IDLE = 2'd0,
    ENT_PUSH = 2'd1,
    ENT_HOLD = 2'd2
  } ent_state_t;

  // Return address written by a call
  function automatic logic [PC_W-1:0] call_ret_addr(input logic [PC_W-1:0] pc);
    return pc + PC_W'(2);
  endfunction

  // Lowest set index wins
  function automatic logic [VEC_W-1:0] pick_level(input logic [NREQ-1:0] req);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req[i]) r = VEC_W'(i);
    end
    return r;
  endfunction

  function automatic logic [NREQ-1:0] level_mask(input logic [VEC_W-1:0] idx);
    return NREQ'(1) << idx;
  endfunction
endpackage

// File: rtl/rs_lifo.sv
module rs_lifo #(
  parameter int W = 16,
  parameter int DEPTH = 6,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  top,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          unf
);
  logic [W-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic full_w, empty_w;

  assign full_w  = (cnt_q == CW'(DEPTH));
  assign empty_w = (cnt_q == '0);
  assign count   = cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (push && !full_w && cnt_q == CW'(g)) mem[g] <= din;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) top = mem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else if (push) begin
      if (full_w) ovf <= 1'b1;
      else        cnt_q <= cnt_q + CW'(1);
    end else if (pop) begin
      if (empty_w) unf <= 1'b1;
      else         cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/rs_irq_pend.sv
module rs_irq_pend #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    assign rise[g] = irq[g] & ~prev_q[g];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b0;
        pend[g]   <= 1'b0;
      end else begin
        prev_q[g] <= irq[g];
        if (rise[g])     pend[g] <= 1'b1;
        else if (clr[g]) pend[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rs_irq_entry.sv
module rs_irq_entry
  import rs_pkg::*;
#(
  parameter int N = NREQ,
  parameter int W = PC_W,
  localparam int VW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_end,
  input  logic          ei,
  input  logic [N-1:0]  pend,
  input  logic [W-1:0]  pc,
  output logic          accept,
  output logic [N-1:0]  clr,
  output logic          ent_push,
  output logic [W-1:0]  saved_pc,
  output logic          stall,
  output logic [N-1:0]  ack,
  output logic [VW-1:0] vec,
  output logic          gie
);
  ent_state_t st_q;
  logic [VW-1:0] sel_w, sel_q;

  assign sel_w    = pick_level(pend);
  assign accept   = insn_end && gie && (pend != '0) && (st_q == ENT_IDLE);
  assign clr      = accept ? level_mask(sel_w) : '0;
  assign ent_push = (st_q == ENT_PUSH);
  assign stall    = (st_q != ENT_IDLE);
  assign ack      = ent_push ? level_mask(sel_q) : '0;
  assign vec      = sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ENT_IDLE;
      sel_q    <= '0;
      saved_pc <= '0;
      gie      <= 1'b0;
    end else begin
      if (accept)  gie <= 1'b0;
      else if (ei) gie <= 1'b1;
      unique case (st_q)
        ENT_IDLE: if (accept) begin
          st_q     <= ENT_PUSH;
          sel_q    <= sel_w;
          saved_pc <= pc;
        end
        ENT_PUSH: st_q <= ENT_HOLD;
        default:  st_q <= ENT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/retstk_irq_seq.sv
module retstk_irq_seq
  import rs_pkg::*;
#(
  parameter int W = PC_W,
  parameter int DEPTH = 6,
  parameter int N = NREQ,
  localparam int VW = $clog2(N),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic [W-1:0]  pc_i,
  input  logic          ret_i,
  input  logic          insn_end_i,
  input  logic          ei_i,
  input  logic [N-1:0]  irq_i,
  output logic [W-1:0]  ret_pc_o,
  output logic [N-1:0]  ack_o,
  output logic [VW-1:0] vec_o,
  output logic          stall_o,
  output logic          gie_o,
  output logic [N-1:0]  pending_o,
  output logic          overflow_o,
  output logic          underflow_o
);
  logic [N-1:0]  clr_w, rise_w;
  logic          accept_w, ent_push_w, push_w, pop_w;
  logic [W-1:0]  saved_pc_w, din_w;
  logic [CW-1:0] cnt_w;

  rs_irq_pend #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq(irq_i), .clr(clr_w),
    .pend(pending_o), .rise(rise_w)
  );

  rs_irq_entry #(.N(N), .W(W)) u_entry (
    .clk(clk), .rst_n(rst_n), .insn_end(insn_end_i), .ei(ei_i),
    .pend(pending_o), .pc(pc_i), .accept(accept_w), .clr(clr_w),
    .ent_push(ent_push_w), .saved_pc(saved_pc_w), .stall(stall_o),
    .ack(ack_o), .vec(vec_o), .gie(gie_o)
  );

  assign push_w = ent_push_w | (call_i & ~stall_o);
  assign pop_w  = ret_i & ~call_i & ~stall_o;
  assign din_w  = ent_push_w ? saved_pc_w : W'(call_ret_addr(PC_W'(pc_i)));

  rs_lifo #(.W(W), .DEPTH(DEPTH)) u_lifo (
    .clk(clk), .rst_n(rst_n), .push(push_w), .pop(pop_w), .din(din_w),
    .top(ret_pc_o), .count(cnt_w), .ovf(overflow_o), .unf(underflow_o)
  );
endmodule

// File: rtl/retstk_irq_seq_chk.sv
module retstk_irq_seq_chk #(
  parameter int DEPTH = 6,
  parameter int N = 3,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_w,
  input logic          pop_w,
  input logic          ent_push_w,
  input logic          accept_w,
  input logic [CW-1:0] cnt_w,
  input logic [N-1:0]  ack_o,
  input logic          stall_o,
  input logic          gie_o,
  input logic          overflow_o,
  input logic          underflow_o
);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w <= CW'(DEPTH));
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_w && cnt_w == CW'(DEPTH)) |=> (cnt_w == CW'(DEPTH) && overflow_o));
  p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  p_unf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_w && !push_w && cnt_w == '0) |=> (underflow_o && cnt_w == '0));
  p_ack_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));
  p_ack_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (ack_o != '0 && stall_o));
  p_stall_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_o) |=> stall_o);
  p_stall_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && $past(stall_o)) |=> !stall_o);
  p_gie_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !gie_o);
  p_stall_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !ent_push_w) |=> (cnt_w == $past(cnt_w)));
endmodule

bind retstk_irq_seq retstk_irq_seq_chk #(.DEPTH(DEPTH), .N(N), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_w(push_w), .pop_w(pop_w),
  .ent_push_w(ent_push_w), .accept_w(accept_w), .cnt_w(cnt_w),
  .ack_o(ack_o), .stall_o(stall_o), .gie_o(gie_o),
  .overflow_o(overflow_o), .underflow_o(underflow_o)
);

// File: tb/retstk_irq_seq_tb.sv
module retstk_irq_seq_tb;
  logic clk = 1'b0;
  logic rst_n, call_i, ret_i, insn_end_i, ei_i;
  logic [15:0] pc_i;
  logic [2:0] irq_i;
  logic [15:0] ret_pc_o;
  logic [2:0] ack_o, pending_o;
  logic [1:0] vec_o;
  logic stall_o, gie_o, overflow_o, underflow_o;

  int total = 0;
  int bad = 0;
  logic [15:0] mstk [6];
  int mcnt = 0;
  logic movf = 0, munf = 0;

  always #2.5 clk = ~clk;

  retstk_irq_seq u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .pc_i(pc_i), .ret_i(ret_i),
    .insn_end_i(insn_end_i), .ei_i(ei_i), .irq_i(irq_i), .ret_pc_o(ret_pc_o),
    .ack_o(ack_o), .vec_o(vec_o), .stall_o(stall_o), .gie_o(gie_o),
    .pending_o(pending_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  function automatic logic [15:0] plus_two(input logic [15:0] p);
    logic [16:0] s;
    s = {1'b0, p} + 17'd2;
    return s[15:0];
  endfunction

  function automatic logic [15:0] model_top();
    if (mcnt == 0) return 16'h0;
    return mstk[mcnt-1];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    call_i = 0; ret_i = 0; insn_end_i = 0; ei_i = 0;
  endtask

  task automatic m_push(input logic [15:0] v);
    if (mcnt == 6) movf = 1;
    else begin mstk[mcnt] = v; mcnt++; end
  endtask

  task automatic m_pop();
    if (mcnt == 0) munf = 1;
    else mcnt--;
  endtask

  task automatic do_call(input logic [15:0] p);
    call_i = 1; pc_i = p; cyc(); idle();
    m_push(plus_two(p));
  endtask

  task automatic do_ret();
    ret_i = 1; cyc(); idle();
    m_pop();
  endtask

  task automatic reset_all();
    rst_n = 0; idle(); pc_i = 0; irq_i = 0;
    cyc(); cyc(); rst_n = 1; cyc();
    mcnt = 0; movf = 0; munf = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5eed);
    reset_all();
    // R10 reset state
    chk("R10 ret_pc", ret_pc_o, 0);
    chk("R10 pend", pending_o, 0);
    chk("R10 gie", gie_o, 0);
    chk("R10 flags", {overflow_o, underflow_o, stall_o}, 0);
    chk("R10 ack", ack_o, 0);

    // R1 LIFO
    do_call(16'h0100); do_call(16'h0200);
    chk("R1 top plus two", ret_pc_o, 16'h0202);
    do_ret();
    chk("R1 lifo order", ret_pc_o, 16'h0102);
    do_ret();
    chk("R1 empty after pops", ret_pc_o, 0);
    // R3 underflow
    do_ret();
    chk("R3 underflow", underflow_o, 1);
    chk("R3 empty zero", ret_pc_o, 0);
    do_call(16'hFFFF);
    chk("R1 wrap", ret_pc_o, 16'h0001);
    chk("R3 sticky", underflow_o, 1);
    do_ret();

    // R2 full and overflow
    for (int i = 0; i < 6; i++) do_call(16'h1000 + 16'(i * 16));
    chk("R2 full no ovf", overflow_o, 0);
    do_call(16'h7770);
    chk("R2 overflow", overflow_o, 1);
    chk("R2 contents kept", ret_pc_o, model_top());
    for (int i = 0; i < 6; i++) begin
      chk("R2 drain", ret_pc_o, model_top());
      do_ret();
    end

    // R9 call and ret together: call wins
    reset_all();
    do_call(16'h0040);
    call_i = 1; ret_i = 1; pc_i = 16'h0050; cyc(); idle(); m_push(16'h0052);
    chk("R9 call wins", ret_pc_o, 16'h0052);

    // R4 edges, R5 no accept without gie
    irq_i = 3'b110; cyc();
    chk("R4 pending set", pending_o, 3'b110);
    insn_end_i = 1; pc_i = 16'h0AAA; cyc(); idle();
    chk("R5 no accept gie off", stall_o, 0);
    ei_i = 1; cyc(); idle();
    chk("R8 ei sets", gie_o, 1);
    chk("R5 no accept without boundary", stall_o, 0);
    // R6 level 1 chosen over 2
    insn_end_i = 1; ei_i = 1; pc_i = 16'h1234; cyc(); idle();
    chk("R7 stall first", stall_o, 1);
    chk("R6 ack", ack_o, 3'b010);
    chk("R6 vec", vec_o, 1);
    chk("R6 pend kept", pending_o, 3'b100);
    chk("R8 accept wins over ei", gie_o, 0);
    call_i = 1; pc_i = 16'h3333; cyc(); idle();
    chk("R7 stall second", stall_o, 1);
    chk("R6 ack single", ack_o, 0);
    ret_i = 1; cyc(); idle();
    chk("R7 stall ends", stall_o, 0);
    m_push(16'h1234);
    chk("R7 pushed pc", ret_pc_o, 16'h1234);
    chk("R9 ignored during stall", ret_pc_o, model_top());
    // R4 held high no retrigger
    irq_i = 3'b111; cyc(); cyc();
    chk("R4 held no retrigger", pending_o, 3'b101);
    ei_i = 1; cyc(); idle();
    insn_end_i = 1; pc_i = 16'h2000; cyc(); idle();
    chk("R6 level0 first", vec_o, 0);
    chk("R6 ack0", ack_o, 3'b001);
    cyc(); cyc();
    m_push(16'h2000);
    irq_i = 3'b000; cyc();
    chk("R6 pend after 0", pending_o, 3'b100);
    chk("R7 pushed second", ret_pc_o, 16'h2000);

    // R2 interrupt push onto full stack
    while (mcnt < 6) do_call(16'h4000);
    ei_i = 1; cyc(); idle();
    insn_end_i = 1; pc_i = 16'h5555; cyc(); idle();
    chk("R6 vec2", vec_o, 2);
    cyc(); cyc();
    m_push(16'h5555);
    chk("R2 irq overflow", overflow_o, movf);
    chk("R2 irq contents", ret_pc_o, model_top());

    // random phase against model
    reset_all();
    for (int k = 0; k < 400; k++) begin
      r = $urandom();
      case (r[1:0])
        2'd0, 2'd1: do_call(r[31:16]);
        2'd2: do_ret();
        default: cyc();
      endcase
      chk("R1 random top", ret_pc_o, model_top());
      chk("R2 random ovf", overflow_o, movf);
      chk("R3 random unf", underflow_o, munf);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule